// File: doc/BRIEF.md
# Branch condition and target resolver

This unit sits in the execute stage of a 32-bit pipeline. It takes one decoded instruction word per cycle with the execute-stage PC and the two operand register values. For that instruction it decides whether control flow changes, where it goes, whether the following instruction is a delay slot, and whether the current PC must be written to a destination register as a return address. Bits are numbered big-endian: bit 0 is the most significant bit of the word, so the 6-bit opcode is bits 0-5, which is `in_insn[31:26]`.

The unit also holds a one-shot immediate prefix. A prefix instruction supplies the upper 16 bits of the immediate used by the next instruction, which would otherwise sign-extend its own 16-bit field. Three kinds of control transfer are resolved: conditional branches, unconditional jumps (including break and link forms) and return jumps. Each return flavour raises a single-cycle strobe for the status logic. All results are registered and appear one cycle after the instruction is presented.

Top module: `branch_resolver`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and discards any pending immediate prefix, so an immediate instruction issued right after reset uses plain sign extension.
- R2: Each output reflects the instruction presented with `in_valid` high one clock earlier. A cycle with `in_valid` low produces `out_valid`, `br_taken`, `link_we` and all strobes low in the next cycle and consumes no prefix.
- R3: Opcodes 100111 (register form) and 101111 (immediate form) are conditional branches. Bits 7-10 (`in_insn[24:21]`) test the signed value of `in_opa` as follows: 0000 equal to zero, 0001 non-zero, 0010 negative, 0011 negative or zero, 0100 positive, 0101 zero or positive. The target is `in_pc + in_opb` for the register form and `in_pc` plus the immediate for the immediate form. Bit 6 (`in_insn[25]`) requests a delay slot, and `br_delay` is raised only when the branch is taken.
- R4: A conditional branch with condition code 0110 through 1111 is not taken and raises `illegal`.
- R5: Opcodes 100110 (register form) and 101110 (immediate form) always jump. Ra-field bit 11 (`in_insn[20]`) gives a delay slot. Bit 12 (`in_insn[19]`) makes the target absolute: `in_opb` or the immediate alone instead of being added to `in_pc`.
- R6: For an unconditional jump with Ra-field bit 13 (`in_insn[18]`) set, `link_we` is raised, `link_reg` carries the Rd field (`in_insn[25:21]`) and `link_data` carries the instruction's PC. No other instruction raises `link_we`.
- R7: An unconditional jump whose Ra field is exactly 01100 is a break. It jumps to the absolute target, links, and raises `brk_set`.
- R8: Opcode 101101 is a return. It always jumps to `in_opa` plus the immediate with `br_delay` high. Rd field 10001 raises `ie_set`, 10010 raises `brk_clr` and 10100 raises `exc_ret`; any other value raises no strobe. At most one strobe is ever high.
- R9: Opcode 101100 is an immediate prefix. It captures its low 16 bits, and the next valid instruction, if it is an immediate form (opcode bit 2, `in_insn[29]`, set), uses them as bits 31:16 of its immediate with its own field as bits 15:0.
- R10: The prefix is consumed by exactly the next valid instruction, whatever its kind. A register-form or non-branch instruction discards it unused, and a later prefix replaces an earlier one.
- R11: Any opcode not listed above, as well as the prefix itself, gives `out_valid` high with `br_taken`, `br_delay`, `link_we`, `illegal` and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 32 | Instruction word, opcode in [31:26] |
| in_pc | input | XLEN | PC of the instruction |
| in_opa | input | XLEN | Value of register Ra |
| in_opb | input | XLEN | Value of register Rb |
| out_valid | output | 1 | A result is present |
| br_taken | output | 1 | Control flow changes |
| br_target | output | XLEN | Next PC when taken |
| br_delay | output | 1 | Taken transfer has a delay slot |
| link_we | output | 1 | Write return address |
| link_reg | output | 5 | Destination register index |
| link_data | output | XLEN | Return address (instruction PC) |
| brk_set | output | 1 | Set break-in-progress |
| ie_set | output | 1 | Set interrupt enable |
| brk_clr | output | 1 | Clear break-in-progress |
| exc_ret | output | 1 | Exception return |
| illegal | output | 1 | Undefined condition code |

## Verification
On every cycle the assertions check the one-cycle result timing, that idle cycles stay quiet, that illegal codes never branch, that link data is the previous PC, that breaks both link and jump, and that return strobes are exclusive and always come with a delay slot. Target arithmetic, each signed condition at its zero boundary, the absolute and relative selection, and the lifetime of the immediate prefix across gaps, register-form instructions, non-branch instructions and a reset can only be shown by the bench's scenarios, which compare every field against a behavioural model each clock.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned REG_W  = 5;

  localparam logic [5:0] OP_BCC_R = 6'b100111;
  localparam logic [5:0] OP_BCC_I = 6'b101111;
  localparam logic [5:0] OP_JMP_R = 6'b100110;
  localparam logic [5:0] OP_JMP_I = 6'b101110;
  localparam logic [5:0] OP_RET   = 6'b101101;
  localparam logic [5:0] OP_PFX   = 6'b101100;

  localparam logic [4:0] JMP_BREAK = 5'b01100;
  localparam logic [4:0] RET_IE    = 5'b10001;
  localparam logic [4:0] RET_BRK   = 5'b10010;
  localparam logic [4:0] RET_EXC   = 5'b10100;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0, CC_NE = 4'd1, CC_LT = 4'd2,
    CC_LE = 4'd3, CC_GT = 4'd4, CC_GE = 4'd5
  } cond_e;

  typedef struct packed {
    logic taken;
    logic delay;
    logic link_we;
    logic brk_set;
    logic ie_set;
    logic brk_clr;
    logic exc_ret;
    logic illegal;
  } resolve_t;
endpackage

// File: rtl/bru_prefix.sv
module bru_prefix
  import bru_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              is_prefix,
  input  logic [HALF_W-1:0] imm_lo,
  output logic              pfx_valid,
  output logic [HALF_W-1:0] pfx_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pfx_valid <= 1'b0;
      pfx_hi    <= '0;
    end else if (in_valid) begin
      pfx_valid <= is_prefix;
      if (is_prefix) pfx_hi <= imm_lo;
    end
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] value,
  input  logic [3:0]      code,
  output logic            hit,
  output logic            bad
);
  logic is_zero, is_neg;
  assign is_zero = (value == '0);
  assign is_neg  = value[XLEN-1];

  always_comb begin
    hit = 1'b0;
    bad = 1'b0;
    case (code)
      CC_EQ:   hit = is_zero;
      CC_NE:   hit = !is_zero;
      CC_LT:   hit = is_neg;
      CC_LE:   hit = is_neg || is_zero;
      CC_GT:   hit = !is_neg && !is_zero;
      CC_GE:   hit = !is_neg;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic              pfx_valid,
  input  logic [HALF_W-1:0] pfx_hi,
  output resolve_t          res,
  output logic [XLEN-1:0]   target,
  output logic              is_prefix
);
  logic [5:0]        opc;
  logic [REG_W-1:0]  fd, fa;
  logic [HALF_W-1:0] imm16;
  logic              imm_form;
  logic signed [INSN_W-1:0] imm_w;
  logic [XLEN-1:0]   imm_x, base, offs;
  logic              cc_hit, cc_bad;

  assign opc      = insn[31:26];
  assign fd       = insn[25:21];
  assign fa       = insn[20:16];
  assign imm16    = insn[15:0];
  assign imm_form = insn[29];
  assign is_prefix = (opc == OP_PFX);

  always_comb begin
    if (imm_form && pfx_valid) imm_w = {pfx_hi, imm16};
    else                       imm_w = {{HALF_W{imm16[HALF_W-1]}}, imm16};
  end
  assign imm_x = XLEN'(imm_w);

  bru_cond #(.XLEN(XLEN)) u_cond (
    .value (opa),
    .code  (fd[3:0]),
    .hit   (cc_hit),
    .bad   (cc_bad)
  );

  // one shared adder: base selects pc, opa or zero; offset selects opb or immediate
  assign offs   = imm_form ? imm_x : opb;
  assign target = base + offs;

  always_comb begin
    res  = '0;
    base = pc;
    case (opc)
      OP_BCC_R, OP_BCC_I: begin
        res.taken   = cc_hit;
        res.illegal = cc_bad;
        res.delay   = cc_hit && fd[4];
      end
      OP_JMP_R, OP_JMP_I: begin
        res.taken   = 1'b1;
        res.delay   = fa[4];
        res.link_we = fa[2];
        res.brk_set = (fa == JMP_BREAK);
        if (fa[3]) base = '0;
      end
      OP_RET: begin
        res.taken   = 1'b1;
        res.delay   = 1'b1;
        res.ie_set  = (fd == RET_IE);
        res.brk_clr = (fd == RET_BRK);
        res.exc_ret = (fd == RET_EXC);
        base        = opa;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import bru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_opa,
  input  logic [XLEN-1:0]   in_opb,
  output logic              out_valid,
  output logic              br_taken,
  output logic [XLEN-1:0]   br_target,
  output logic              br_delay,
  output logic              link_we,
  output logic [4:0]        link_reg,
  output logic [XLEN-1:0]   link_data,
  output logic              brk_set,
  output logic              ie_set,
  output logic              brk_clr,
  output logic              exc_ret,
  output logic              illegal
);
  logic              pfx_valid, is_prefix;
  logic [HALF_W-1:0] pfx_hi;
  resolve_t          res_d, res_q;
  logic [XLEN-1:0]   target_d;

  bru_prefix u_prefix (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .is_prefix (is_prefix),
    .imm_lo    (in_insn[15:0]),
    .pfx_valid (pfx_valid),
    .pfx_hi    (pfx_hi)
  );

  bru_decode #(.XLEN(XLEN)) u_decode (
    .insn      (in_insn),
    .pc        (in_pc),
    .opa       (in_opa),
    .opb       (in_opb),
    .pfx_valid (pfx_valid),
    .pfx_hi    (pfx_hi),
    .res       (res_d),
    .target    (target_d),
    .is_prefix (is_prefix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      br_target <= '0;
      link_reg  <= '0;
      link_data <= '0;
    end else begin
      out_valid <= in_valid;
      res_q     <= in_valid ? res_d : '0;
      if (in_valid) begin
        br_target <= target_d;
        link_reg  <= in_insn[25:21];
        link_data <= in_pc;
      end
    end
  end

  assign br_taken = res_q.taken;
  assign br_delay = res_q.delay;
  assign link_we  = res_q.link_we;
  assign brk_set  = res_q.brk_set;
  assign ie_set   = res_q.ie_set;
  assign brk_clr  = res_q.brk_clr;
  assign exc_ret  = res_q.exc_ret;
  assign illegal  = res_q.illegal;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     in_insn,
  input logic [XLEN-1:0] in_pc,
  input logic [XLEN-1:0] in_opa,
  input logic            out_valid,
  input logic            br_taken,
  input logic            br_delay,
  input logic            link_we,
  input logic [XLEN-1:0] link_data,
  input logic            brk_set,
  input logic            ie_set,
  input logic            brk_clr,
  input logic            exc_ret,
  input logic            illegal
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !br_taken && !link_we && !illegal));

  p_eq_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[31:26] == 6'b100111 && in_insn[24:21] == 4'd0)
      |=> (br_taken == ($past(in_opa) == '0)));

  p_illegal_not_taken_r4: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !br_taken);

  p_link_pc_r6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_data == $past(in_pc)));

  p_break_links_r7: assert property (@(posedge clk) disable iff (rst)
    brk_set |-> (br_taken && link_we));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({brk_set, ie_set, brk_clr, exc_ret}));

  p_return_delay_r8: assert property (@(posedge clk) disable iff (rst)
    (ie_set || brk_clr || exc_ret) |-> (br_taken && br_delay));
endmodule

bind branch_resolver branch_resolver_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_insn   (in_insn),
  .in_pc     (in_pc),
  .in_opa    (in_opa),
  .out_valid (out_valid),
  .br_taken  (br_taken),
  .br_delay  (br_delay),
  .link_we   (link_we),
  .link_data (link_data),
  .brk_set   (brk_set),
  .ie_set    (ie_set),
  .brk_clr   (brk_clr),
  .exc_ret   (exc_ret),
  .illegal   (illegal)
);

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0, in_pc = '0, in_opa = '0, in_opb = '0;
  logic        out_valid, br_taken, br_delay, link_we;
  logic [31:0] br_target, link_data;
  logic [4:0]  link_reg;
  logic        brk_set, ie_set, brk_clr, exc_ret, illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  branch_resolver #(.XLEN(32)) i_branch_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_pc(in_pc), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .br_taken(br_taken), .br_target(br_target),
    .br_delay(br_delay), .link_we(link_we), .link_reg(link_reg),
    .link_data(link_data), .brk_set(brk_set), .ie_set(ie_set),
    .brk_clr(brk_clr), .exc_ret(exc_ret), .illegal(illegal)
  );

  // behavioural model state
  bit          m_pfx_v = 0;
  bit [15:0]   m_pfx = 0;
  string       e_tag = "";
  bit [8:0]    e_flags = 0;   // valid,taken,delay,lwe,bset,ie,bclr,exc,ill
  bit [31:0]   e_target = 0, e_ldata = 0;
  bit [4:0]    e_lreg = 0;

  function automatic bit [31:0] enc(int op, int fd, int fa, int low);
    return (32'(op) << 26) | (32'(fd) << 21) | (32'(fa) << 16) | 32'(low & 16'hFFFF);
  endfunction

  task automatic compare();
    bit [8:0] act;
    bit bad;
    if (e_tag == "") return;
    act = {out_valid, br_taken, br_delay, link_we, brk_set, ie_set, brk_clr, exc_ret, illegal};
    bad = (act != e_flags);
    if (e_flags[7] && br_target != e_target) bad = 1;
    if (e_flags[5] && (link_reg != e_lreg || link_data != e_ldata)) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: flags %b target %h link %0d/%h, expected flags %b target %h link %0d/%h",
               e_tag, act, br_target, link_reg, link_data, e_flags, e_target, e_lreg, e_ldata);
    end
  endtask

  // compare previous result, then present a new instruction and predict it
  task automatic step(string tag, bit v, bit [31:0] ins, bit [31:0] pc, bit [31:0] a, bit [31:0] b);
    int op, fd, fa, code;
    bit [31:0] imm, off;
    bit t, ill;
    @(negedge clk);
    compare();
    in_valid = v; in_insn = ins; in_pc = pc; in_opa = a; in_opb = b;
    op = int'(ins[31:26]); fd = int'(ins[25:21]); fa = int'(ins[20:16]);
    if (ins[29] && m_pfx_v) imm = {m_pfx, ins[15:0]};
    else imm = 32'($signed(ins[15:0]));
    e_tag = tag; e_flags = 0; e_target = 0; e_lreg = ins[25:21]; e_ldata = pc;
    if (v) begin
      e_flags[8] = 1;
      off = ins[29] ? imm : b;
      if (op == 'h27 || op == 'h2F) begin
        code = fd % 16; ill = 0;
        case (code)
          0: t = ($signed(a) == 0);
          1: t = ($signed(a) != 0);
          2: t = ($signed(a) < 0);
          3: t = ($signed(a) <= 0);
          4: t = ($signed(a) > 0);
          5: t = ($signed(a) >= 0);
          default: begin t = 0; ill = 1; end
        endcase
        e_flags[7] = t; e_flags[6] = t && (fd >= 16); e_flags[0] = ill;
        e_target = pc + off;
      end else if (op == 'h26 || op == 'h2E) begin
        e_flags[7] = 1; e_flags[6] = fa[4]; e_flags[5] = fa[2];
        e_flags[4] = (fa == 12);
        e_target = fa[3] ? off : pc + off;
      end else if (op == 'h2D) begin
        e_flags[7] = 1; e_flags[6] = 1;
        e_flags[3] = (fd == 17); e_flags[2] = (fd == 18); e_flags[1] = (fd == 20);
        e_target = a + imm;
      end
      if (op == 'h2C) begin m_pfx_v = 1; m_pfx = ins[15:0]; end
      else m_pfx_v = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare();
    in_valid = 0; rst = 1; e_tag = ""; m_pfx_v = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if ({out_valid, br_taken, br_delay, link_we, brk_set, ie_set, brk_clr, exc_ret, illegal} != 0
        || br_target != 0 || link_data != 0 || link_reg != 0) begin
      errors++;
      $display("FAIL R1: outputs %b target %h after reset, expected all zero",
               {out_valid, br_taken, link_we, illegal}, br_target);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vals[5];
    vals = '{-5, -1, 0, 1, 7};
    repeat (3) @(negedge clk);
    do_reset();

    // R3: all conditions, both forms, around the zero boundary
    for (int c = 0; c < 6; c++)
      for (int k = 0; k < 5; k++) begin
        step("R3", 1, enc('h27, c + 16 * (k % 2), 3, 4 << 11), 32'h1000, 32'(vals[k]), 32'h40);
        step("R3", 1, enc('h2F, c + 16 * ((k + 1) % 2), 3, -8), 32'h2000, 32'(vals[k]), 0);
      end
    // R4: undefined condition codes
    for (int c = 6; c < 16; c++)
      step("R4", 1, enc('h2F, c, 3, 16), 32'h3000, 0, 0);
    // R5, R6, R7: every flag combination on the unconditional forms
    for (int f = 0; f < 32; f += 4) begin
      step(f == 12 ? "R7" : "R5", 1, enc('h26, 9, f, 0), 32'h4000, 0, 32'h0000_0120);
      step(f[2] ? "R6" : "R5", 1, enc('h2E, 15, f, -64), 32'h5000, 0, 0);
    end
    // R8: return subcodes
    foreach (vals[k]) begin
      int codes[5];
      codes = '{16, 17, 18, 20, 3};
      step("R8", 1, enc('h2D, codes[k], 0, 12), 32'h6000, 32'h7000 + 32'(k), 0);
    end
    // R9: prefix widens the next immediate
    step("R11", 1, enc('h2C, 0, 0, 'h1234), 32'h100, 0, 0);
    step("R9", 1, enc('h2F, 0, 3, 'h8000), 32'h200, 0, 0);
    step("R9", 1, enc('h2C, 0, 0, 'hFFFF), 32'h100, 0, 0);
    step("R9", 1, enc('h2E, 0, 8, 'h0010), 32'h200, 0, 0);
    // R10: gaps keep it, register forms and non-branches consume it, newer replaces older
    step("R10", 1, enc('h2C, 0, 0, 'h00AB), 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    step("R10", 1, enc('h2E, 0, 0, 'h8000), 32'h300, 0, 0);
    step("R10", 1, enc('h2C, 0, 0, 'h0055), 0, 0, 0);
    step("R10", 1, enc('h26, 0, 0, 0), 32'h400, 0, 32'h8);
    step("R10", 1, enc('h2E, 0, 0, 'h8000), 32'h400, 0, 0);
    step("R10", 1, enc('h2C, 0, 0, 'h0077), 0, 0, 0);
    step("R11", 1, enc('h28, 1, 2, 5), 0, 0, 0);
    step("R10", 1, enc('h2E, 0, 0, 'h9000), 32'h500, 0, 0);
    step("R10", 1, enc('h2C, 0, 0, 'h1111), 0, 0, 0);
    step("R10", 1, enc('h2C, 0, 0, 'h2222), 0, 0, 0);
    step("R10", 1, enc('h2D, 17, 0, 4), 0, 32'h10, 0);
    // R11: non-branch opcodes
    step("R11", 1, enc('h00, 4, 4, 0), 32'h600, 1, 2);
    step("R11", 1, enc('h32, 31, 4, 0), 32'h604, 1, 2);
    step("R11", 1, enc('h3E, 12, 12, 0), 32'h608, 0, 0);
    // R1: pending prefix is dropped by reset
    step("R1", 1, enc('h2C, 0, 0, 'h4444), 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    do_reset();
    step("R1", 1, enc('h2E, 0, 8, 'hFFF0), 32'h800, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule